// File: doc/BRIEF.md
# PFC Supervisor with Ready Flag and Soft-Start

This block supervises a critical-conduction boost PFC controller. It takes sampled digital codes of the chip supply and of the divided-down PFC output, plus a flag from an external detector that reports missing line input. From these it produces four things:

- a run enable for the switching logic;
- an over-voltage shutdown flag for the gate sequencer;
- the pull-down enable of an open-drain ready pin;
- the code of the internal regulation reference.

It also drives a select line that tells the loop whether to use an internal proportional controller or the external compensator.

Each threshold comparison is made against a registered sample. Each comparator result is kept in its own flip-flop, so the hysteresis bands are exact.

The reference is handled in three ways:

- It sits at zero while the supply is locked out or the line input is missing.
- Otherwise it climbs to its target in equal stair steps.
- Once the output has reached the target, a timer hands control over to the external compensator.

Top module: `pfc_supervisor`

## Requirements
- R1: Supply codes are 0.1 V per LSB. Operation is enabled on a supply sample of at least 120 and stays enabled until a sample below 85. `runEn` is high only while operation is enabled and the disable state is inactive.
- R2: Output codes are 1 mV per LSB. `shutdown` goes high on a sample above 2675 and goes low on a sample below 2500. Samples from 2500 to 2675 keep its state.
- R3: The disable state is entered on an output sample below 350 and left on a sample of at least 450. While it is active, `runEn` is low.
- R4: Ready goes high on an output sample above 2240 and goes low on a sample below 2051. `readyPullDn` is the inverse of ready (1 = pin pulled low).
- R5: Ready cannot go high unless operation is enabled or the current supply sample is at least 120, whatever the output level.
- R6: After operation stops, ready keeps its state while the supply sample stays at 50 or more. A supply sample below 50 forces ready low.
- R7: The reference code rises through STEPS equal levels, each held DWELL cycles. Level k is k*(TARGET/STEPS), and the last level is exactly TARGET. It never exceeds TARGET.
- R8: The reference code is zero while operation is not enabled or the input-absent flag is active. The staircase restarts from zero once both conditions clear.
- R9: `useExtComp` is 0 until an output sample of at least TARGET is seen while operating. It becomes 1 HANDOVER cycles later and returns to 0 whenever soft-start is reset.
- R10: A change on any input reaches the comparator outputs after two rising clock edges.
- R11: During reset, `runEn`, `shutdown`, `refCode` and `useExtComp` are 0 and `readyPullDn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| supplyCode | input | SUP_W | Supply voltage sample, 0.1 V/LSB |
| fbCode | input | FB_W | Scaled output voltage sample, 1 mV/LSB |
| inputAbsent | input | 1 | Line input missing |
| runEn | output | 1 | Switching allowed |
| shutdown | output | 1 | Over-voltage shutdown to gate sequencer |
| readyPullDn | output | 1 | Ready pin pull-down enable |
| refCode | output | FB_W | Internal reference code |
| useExtComp | output | 1 | 1 selects the external compensator |

## Verification
The bench builds the block with STEPS=4, DWELL=5 and HANDOVER=8, while the thresholds keep their default values. With these values the whole staircase (625, 1250, 1875, 2500) and the handover delay fit within a few dozen cycles. The exact edge on which each level and the select line change can therefore be checked, as can the restart after a missing-input pulse. The threshold codes are probed one code either side of the over-voltage set and release points. They are also walked through the ready, disable and lockout hysteresis bands.

// File: rtl/pfc_sup_pkg.sv
package pfc_sup_pkg;
  typedef struct packed {
    logic ssClear;    // soft-start and handover reset
    logic ratedSeen;  // output has reached the target while operating
  } supStrobe_t;
endpackage

// File: rtl/pfc_sup_ctrl.sv
module pfc_sup_ctrl
  import pfc_sup_pkg::*;
#(
  parameter int SUP_W    = 8,
  parameter int FB_W     = 12,
  parameter int SUP_ON   = 120,
  parameter int SUP_OFF  = 85,
  parameter int SUP_LIVE = 50,
  parameter int OVP_SET  = 2675,
  parameter int OVP_REL  = 2500,
  parameter int DIS_SET  = 350,
  parameter int DIS_REL  = 450,
  parameter int RDY_SET  = 2240,
  parameter int RDY_CLR  = 2051,
  parameter int TARGET   = 2500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SUP_W-1:0] supplyCode,
  input  logic [FB_W-1:0]  fbCode,
  input  logic             inputAbsent,
  output logic             runEn,
  output logic             shutdown,
  output logic             readyPullDn,
  output supStrobe_t       stb
);
  localparam logic [SUP_W-1:0] SUP_ON_C   = SUP_W'(SUP_ON);
  localparam logic [SUP_W-1:0] SUP_OFF_C  = SUP_W'(SUP_OFF);
  localparam logic [SUP_W-1:0] SUP_LIVE_C = SUP_W'(SUP_LIVE);
  localparam logic [FB_W-1:0]  OVP_SET_C  = FB_W'(OVP_SET);
  localparam logic [FB_W-1:0]  OVP_REL_C  = FB_W'(OVP_REL);
  localparam logic [FB_W-1:0]  DIS_SET_C  = FB_W'(DIS_SET);
  localparam logic [FB_W-1:0]  DIS_REL_C  = FB_W'(DIS_REL);
  localparam logic [FB_W-1:0]  RDY_SET_C  = FB_W'(RDY_SET);
  localparam logic [FB_W-1:0]  RDY_CLR_C  = FB_W'(RDY_CLR);
  localparam logic [FB_W-1:0]  TARGET_C   = FB_W'(TARGET);

  logic [SUP_W-1:0] supReg;
  logic [FB_W-1:0]  fbReg;
  logic absReg, absOn;
  logic supOn, supAlive, ovpOn, disOn, rdyOn, ratedOn;

  // stage 1: registered samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      supReg <= '0;
      fbReg  <= '0;
      absReg <= 1'b0;
    end else begin
      supReg <= supplyCode;
      fbReg  <= fbCode;
      absReg <= inputAbsent;
    end
  end

  logic clearNow;
  assign clearNow = !supOn || absOn;

  // stage 2: one flip-flop per comparator state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      supOn    <= 1'b0;
      supAlive <= 1'b0;
      ovpOn    <= 1'b0;
      disOn    <= 1'b0;
      rdyOn    <= 1'b0;
      absOn    <= 1'b0;
      ratedOn  <= 1'b0;
    end else begin
      if (supReg >= SUP_ON_C)     supOn <= 1'b1;
      else if (supReg < SUP_OFF_C) supOn <= 1'b0;

      supAlive <= (supReg >= SUP_LIVE_C);

      if (fbReg > OVP_SET_C)      ovpOn <= 1'b1;
      else if (fbReg < OVP_REL_C) ovpOn <= 1'b0;

      if (fbReg < DIS_SET_C)       disOn <= 1'b1;
      else if (fbReg >= DIS_REL_C) disOn <= 1'b0;

      if (supReg < SUP_LIVE_C || fbReg < RDY_CLR_C)
        rdyOn <= 1'b0;
      else if (fbReg > RDY_SET_C && (supOn || supReg >= SUP_ON_C))
        rdyOn <= 1'b1;

      absOn <= absReg;

      if (clearNow)                          ratedOn <= 1'b0;
      else if (fbReg >= TARGET_C)            ratedOn <= 1'b1;
    end
  end

  assign runEn         = supOn && !disOn;
  assign shutdown      = ovpOn;
  assign readyPullDn   = !rdyOn;
  assign stb.ssClear   = clearNow;
  assign stb.ratedSeen = ratedOn;

  p_ready_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdyOn) |-> supOn);
  p_ready_dead_r6: assert property (@(posedge clk) disable iff (!rstN)
    !supAlive |-> !rdyOn);
  p_ovp_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovpOn) |-> ($past(fbReg) > OVP_SET_C));
  p_dis_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(disOn) |-> ($past(fbReg) >= DIS_REL_C));
  p_uvlo_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(supOn) |-> ($past(supReg) >= SUP_ON_C));
endmodule

// File: rtl/pfc_sup_dp.sv
module pfc_sup_dp
  import pfc_sup_pkg::*;
#(
  parameter int FB_W     = 12,
  parameter int TARGET   = 2500,
  parameter int STEPS    = 16,
  parameter int DWELL    = 312,
  parameter int HANDOVER = 30000
) (
  input  logic            clk,
  input  logic            rstN,
  input  supStrobe_t      stb,
  output logic [FB_W-1:0] refCode,
  output logic            useExtComp
);
  localparam int LVL_W = $clog2(STEPS + 1);
  localparam int DW_W  = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam int HO_W  = (HANDOVER > 1) ? $clog2(HANDOVER) : 1;
  localparam logic [FB_W-1:0]  TARGET_C = FB_W'(TARGET);
  localparam logic [FB_W-1:0]  STEP_C   = FB_W'(TARGET / STEPS);
  localparam logic [LVL_W-1:0] TOP_LVL  = LVL_W'(STEPS);
  localparam logic [DW_W-1:0]  DW_LAST  = DW_W'(DWELL - 1);
  localparam logic [HO_W-1:0]  HO_LAST  = HO_W'(HANDOVER - 1);

  logic [LVL_W-1:0] level;
  logic [DW_W-1:0]  dwellCnt;
  logic [HO_W-1:0]  hoCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level      <= '0;
      dwellCnt   <= '0;
      hoCnt      <= '0;
      useExtComp <= 1'b0;
    end else if (stb.ssClear) begin
      level      <= '0;
      dwellCnt   <= '0;
      hoCnt      <= '0;
      useExtComp <= 1'b0;
    end else begin
      if (level != TOP_LVL) begin
        if (dwellCnt == DW_LAST) begin
          dwellCnt <= '0;
          level    <= level + 1'b1;
        end else begin
          dwellCnt <= dwellCnt + 1'b1;
        end
      end
      if (stb.ratedSeen && !useExtComp) begin
        if (hoCnt == HO_LAST) useExtComp <= 1'b1;
        else                  hoCnt      <= hoCnt + 1'b1;
      end
    end
  end

  // last level lands exactly on the target even when it does not divide evenly
  assign refCode = (level == TOP_LVL) ? TARGET_C
                                      : FB_W'(FB_W'(level) * STEP_C);

  p_ref_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.ssClear |=> (refCode == '0));
  p_ref_rising_r7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ssClear |=> (refCode >= $past(refCode)));
  p_ref_cap_r7: assert property (@(posedge clk) disable iff (!rstN)
    refCode <= TARGET_C);
  p_handover_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(useExtComp) |-> $past(stb.ratedSeen));
endmodule

// File: rtl/pfc_supervisor.sv
module pfc_supervisor
  import pfc_sup_pkg::*;
#(
  parameter int SUP_W    = 8,
  parameter int FB_W     = 12,
  parameter int SUP_ON   = 120,
  parameter int SUP_OFF  = 85,
  parameter int SUP_LIVE = 50,
  parameter int OVP_SET  = 2675,
  parameter int OVP_REL  = 2500,
  parameter int DIS_SET  = 350,
  parameter int DIS_REL  = 450,
  parameter int RDY_SET  = 2240,
  parameter int RDY_CLR  = 2051,
  parameter int TARGET   = 2500,
  parameter int STEPS    = 16,
  parameter int DWELL    = 312,
  parameter int HANDOVER = 30000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SUP_W-1:0] supplyCode,
  input  logic [FB_W-1:0]  fbCode,
  input  logic             inputAbsent,
  output logic             runEn,
  output logic             shutdown,
  output logic             readyPullDn,
  output logic [FB_W-1:0]  refCode,
  output logic             useExtComp
);
  supStrobe_t stb;

  pfc_sup_ctrl #(
    .SUP_W(SUP_W), .FB_W(FB_W), .SUP_ON(SUP_ON), .SUP_OFF(SUP_OFF),
    .SUP_LIVE(SUP_LIVE), .OVP_SET(OVP_SET), .OVP_REL(OVP_REL),
    .DIS_SET(DIS_SET), .DIS_REL(DIS_REL), .RDY_SET(RDY_SET),
    .RDY_CLR(RDY_CLR), .TARGET(TARGET)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .supplyCode(supplyCode), .fbCode(fbCode),
    .inputAbsent(inputAbsent), .runEn(runEn), .shutdown(shutdown),
    .readyPullDn(readyPullDn), .stb(stb)
  );

  pfc_sup_dp #(
    .FB_W(FB_W), .TARGET(TARGET), .STEPS(STEPS), .DWELL(DWELL),
    .HANDOVER(HANDOVER)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .refCode(refCode),
    .useExtComp(useExtComp)
  );
endmodule

// File: tb/test_pfc_supervisor.sv
module test_pfc_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0]  supplyCode = '0;
  logic [11:0] fbCode = '0;
  logic inputAbsent = 1'b0;
  logic runEn, shutdown, readyPullDn, useExtComp;
  logic [11:0] refCode;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfc_supervisor #(.STEPS(4), .DWELL(5), .HANDOVER(8)) i_pfc_supervisor (
    .clk(clk), .rstN(rstN), .supplyCode(supplyCode), .fbCode(fbCode),
    .inputAbsent(inputAbsent), .runEn(runEn), .shutdown(shutdown),
    .readyPullDn(readyPullDn), .refCode(refCode), .useExtComp(useExtComp)
  );

  // {supply, output, expRun, expShutdown, expPullDn}; applied in order, each
  // sampled two edges after the change (R10)
  localparam logic [22:0] VEC [NV] = '{
    {8'd100, 12'd2300, 1'b0, 1'b0, 1'b1},  // R5 not started: no ready
    {8'd125, 12'd2300, 1'b1, 1'b0, 1'b0},  // R1 start, R4 ready
    {8'd125, 12'd2100, 1'b1, 1'b0, 1'b0},  // R4 held inside band
    {8'd125, 12'd2000, 1'b1, 1'b0, 1'b1},  // R4 cleared
    {8'd125, 12'd2300, 1'b1, 1'b0, 1'b0},
    {8'd90,  12'd2300, 1'b1, 1'b0, 1'b0},  // R1 hysteresis keeps running
    {8'd80,  12'd2300, 1'b0, 1'b0, 1'b0},  // R1 stop, R6 ready kept
    {8'd60,  12'd2300, 1'b0, 1'b0, 1'b0},  // R6
    {8'd40,  12'd2300, 1'b0, 1'b0, 1'b1},  // R6 forced low
    {8'd100, 12'd2300, 1'b0, 1'b0, 1'b1},  // R5 no restart below start
    {8'd125, 12'd2700, 1'b1, 1'b1, 1'b0},  // R2 set, R5 same-cycle start
    {8'd125, 12'd2600, 1'b1, 1'b1, 1'b0},  // R2 held
    {8'd125, 12'd2490, 1'b1, 1'b0, 1'b0},  // R2 release
    {8'd125, 12'd300,  1'b0, 1'b0, 1'b1},  // R3 disable
    {8'd125, 12'd400,  1'b0, 1'b0, 1'b1},  // R3 held
    {8'd125, 12'd460,  1'b1, 1'b0, 1'b1},  // R3 released
    {8'd125, 12'd2675, 1'b1, 1'b0, 1'b0},  // R2 at set code: no trip
    {8'd125, 12'd2676, 1'b1, 1'b1, 1'b0},  // R2 one above
    {8'd125, 12'd2500, 1'b1, 1'b1, 1'b0},  // R2 at release code: held
    {8'd125, 12'd2499, 1'b1, 1'b0, 1'b0}   // R2 one below
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/2);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    supplyCode = '0;
    fbCode = '0;
    inputAbsent = 1'b0;
    tick(3);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD/2);
    tick(3);
    // R11 reset state
    check("R11 runEn", runEn, 0);
    check("R11 shutdown", shutdown, 0);
    check("R11 readyPullDn", readyPullDn, 1);
    check("R11 refCode", refCode, 0);
    check("R11 useExtComp", useExtComp, 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      supplyCode = VEC[i][22:15];
      fbCode     = VEC[i][14:3];
      tick(2);
      check($sformatf("R1 run vec%0d", i), runEn, VEC[i][2]);
      check($sformatf("R2 shutdown vec%0d", i), shutdown, VEC[i][1]);
      check($sformatf("R4 pulldown vec%0d", i), readyPullDn, VEC[i][0]);
    end

    // R7 staircase
    doReset();
    supplyCode = 8'd125;
    fbCode = 12'd2300;
    tick(2);
    check("R8 ref at start", refCode, 0);
    for (int k = 1; k <= 4; k++) begin
      tick(4);
      check("R7 dwell hold", refCode, (k - 1) * 625);
      tick(1);
      check("R7 level", refCode, (k == 4) ? 2500 : k * 625);
    end
    tick(5);
    check("R7 capped", refCode, 2500);
    check("R9 no handover below target", useExtComp, 0);

    // R8 missing input
    inputAbsent = 1'b1;
    tick(3);
    check("R8 absent clears", refCode, 0);
    tick(10);
    check("R8 absent holds zero", refCode, 0);
    inputAbsent = 1'b0;
    tick(2);
    check("R8 restart zero", refCode, 0);
    tick(5);
    check("R8 restart first level", refCode, 625);

    // R8 lockout
    supplyCode = 8'd80;
    tick(3);
    check("R8 lockout ref", refCode, 0);
    check("R1 lockout run", runEn, 0);

    // R9 handover
    supplyCode = 8'd125;
    tick(3);
    fbCode = 12'd2500;
    tick(2);
    check("R9 select before delay", useExtComp, 0);
    tick(7);
    check("R9 select one short", useExtComp, 0);
    tick(1);
    check("R9 select after delay", useExtComp, 1);
    inputAbsent = 1'b1;
    tick(3);
    check("R9 select reset", useExtComp, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule